// File: doc/BRIEF.md
# Virtual-to-Physical Translation Unit with Hardware Table Walk

This block maps 32-bit virtual addresses onto physical addresses for pages of 4 KB. Every accepted request is first compared against all tags of a small fully associative translation cache in the same cycle. If a tag matches, the frame number comes straight from that entry. If no tag matches, a hardware walker reads two levels of page tables from memory, one read after the other. It installs the result in the cache when the leaf entry is valid.

The top-level table starts at the frame held in a root-frame register, which software loads through a one-cycle write strobe. Each table is 1024 words of 4 bytes, so a table exactly fills one page. Entries carry a valid flag and a read-only flag. A lookup reports a fault when it reaches an invalid entry, or when a write targets a read-only page. A flush input empties the cache on a context switch. A flush that arrives while a walk is in flight abandons that walk and reports a retry status.

Top module: `mmu_xlate`

## Requirements
- R1: A successful translation returns a physical address equal to the 20-bit frame number followed by the unchanged 12-bit offset (vaddr[11:0]).
- R2: A request whose page is cached responds in the cycle after acceptance and makes no memory read.
- R3: On a miss the walker issues exactly two reads, one at a time. The first is at {root frame, vaddr[31:22], 2'b00}. The second is issued only after the first read's data returns, at {outer-entry frame, vaddr[21:12], 2'b00}.
- R4: A table entry holds the frame number in bits [31:12], the read-only flag in bit 1 and the valid flag in bit 0. An invalid outer or leaf entry yields status 1 (invalid) with a zero address, and nothing is installed, so a repeat access walks again.
- R5: A write to a read-only page yields status 2 (read-only fault) with a zero address, on the cached path and on the walk path alike. A read of the same page succeeds with status 0.
- R6: The cache holds 8 entries filled in round-robin order. After a flush, the ninth distinct installed page replaces the first while the second stays cached.
- R7: A flush empties the cache, so a page that was cached is walked again.
- R8: A flush during a walk ends it with status 3 (retry), installs nothing and issues no further memory read for that walk.
- R9: A request accepted in the same cycle as a flush sees an empty cache and walks.
- R10: A root-frame write redirects the outer read of every later walk to the new table.
- R11: After reset, req_ready is 1 and rsp_valid and mem_req_valid are 0.
- R12: req_ready stays low while a walk is in flight, and rsp_valid is a single-cycle pulse per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_status | output | 2 | 0 ok, 1 invalid, 2 read-only fault, 3 retry |
| rsp_paddr | output | 32 | Physical address, zero unless status is 0 |
| ptbr_we | input | 1 | Load the root-frame register |
| ptbr_frame | input | 20 | Frame number of the outer table |
| flush | input | 1 | Empty the cache and abort any walk |
| mem_req_valid | output | 1 | Walker read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the table word |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Table word read |

## Verification
A flush can collide with two other actions. The first is the acceptance of a request, where it must mask a tag match so that the request walks. The second is the arrival of walk data, where it must block the install and turn the result into a retry. The bench provokes both by raising flush in a chosen cycle counted from acceptance, including the cycle in which the memory model returns data. It judges the outcome at the ports: the response status, the number of memory reads seen, and whether the next access to the same page hits or walks.

// File: rtl/mmu_pkg.sv
`timescale 1ns/1ps
package mmu_pkg;
   typedef enum logic [1:0] {
      XS_OK       = 2'd0,
      XS_INVALID  = 2'd1,
      XS_READONLY = 2'd2,
      XS_RETRY    = 2'd3
   } xs_e;

   localparam int PTE_V_BIT    = 0;
   localparam int PTE_RO_BIT   = 1;
   localparam int PTE_BYTES_LG = 2;
endpackage

// File: rtl/mmu_tlb.sv
`timescale 1ns/1ps
module mmu_tlb #(
   parameter int TAG_W   = 20,
   parameter int FRAME_W = 20,
   parameter int DEPTH   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [TAG_W-1:0]   lk_tag,
   output logic               lk_hit,
   output logic [FRAME_W-1:0] lk_frame,
   output logic               lk_ro,
   input  logic               clr,
   input  logic               ins_en,
   input  logic [TAG_W-1:0]   ins_tag,
   input  logic [FRAME_W-1:0] ins_frame,
   input  logic               ins_ro
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("mmu_tlb: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic               ent_v     [DEPTH];
   logic               ent_ro    [DEPTH];
   logic [TAG_W-1:0]   ent_tag   [DEPTH];
   logic [FRAME_W-1:0] ent_frame [DEPTH];
   logic [DEPTH-1:0]   match;
   logic [PTR_W-1:0]   fill_ptr;

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
         assign match[g] = ent_v[g] && (ent_tag[g] == lk_tag);
      end
   endgenerate

   always_comb begin
      lk_frame = '0;
      lk_ro    = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         if (match[i]) begin
            lk_frame = lk_frame | ent_frame[i];
            lk_ro    = lk_ro | ent_ro[i];
         end
      end
   end
   assign lk_hit = |match;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_ptr <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            ent_v[i]     <= 1'b0;
            ent_ro[i]    <= 1'b0;
            ent_tag[i]   <= '0;
            ent_frame[i] <= '0;
         end
      end else if (clr) begin
         fill_ptr <= '0;
         for (int i = 0; i < DEPTH; i++) ent_v[i] <= 1'b0;
      end else if (ins_en) begin
         fill_ptr <= fill_ptr + 1'b1;
         for (int i = 0; i < DEPTH; i++) begin
            if (fill_ptr == PTR_W'(i)) begin
               ent_v[i]     <= 1'b1;
               ent_ro[i]    <= ins_ro;
               ent_tag[i]   <= ins_tag;
               ent_frame[i] <= ins_frame;
            end
         end
      end
   end
endmodule

// File: rtl/mmu_walker.sv
`timescale 1ns/1ps
module mmu_walker
   import mmu_pkg::*;
#(
   parameter int IDX_W   = 10,
   parameter int FRAME_W = 20,
   parameter int PA_W    = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [2*IDX_W-1:0]   start_vpn,
   input  logic [FRAME_W-1:0]   root_frame,
   input  logic                 abort_in,
   output logic                 busy,
   output logic                 mem_req_valid,
   input  logic                 mem_req_ready,
   output logic [PA_W-1:0]      mem_req_addr,
   input  logic                 mem_rsp_valid,
   input  logic [PA_W-1:0]      mem_rsp_data,
   output logic                 ins_en,
   output logic [FRAME_W-1:0]   ins_frame,
   output logic                 ins_ro,
   output logic                 done,
   output logic [1:0]           done_status,
   output logic [FRAME_W-1:0]   done_frame,
   output logic                 done_ro
);
   localparam int OFF_W = PA_W - FRAME_W;

   generate
      if (FRAME_W + IDX_W + PTE_BYTES_LG != PA_W) begin : g_bad_geom
         $error("mmu_walker: one table must fill exactly one page");
      end
   endgenerate

   typedef enum logic [2:0] {W_IDLE, W_OREQ, W_OWAIT, W_IREQ, W_IWAIT} wst_e;

   wst_e                 st;
   logic [2*IDX_W-1:0]   vpn_q;
   logic [FRAME_W-1:0]   root_q;
   logic [FRAME_W-1:0]   leaf_tbl_q;
   logic                 aborted_q;
   logic [IDX_W-1:0]     idx;
   logic [FRAME_W-1:0]   tbl;
   logic                 rsp_ok;
   logic                 pte_v;
   logic                 pte_unused_bits;

   assign pte_v           = mem_rsp_data[PTE_V_BIT];
   assign pte_unused_bits = ^mem_rsp_data[OFF_W-1:PTE_RO_BIT+1];
   assign rsp_ok          = mem_rsp_valid && !aborted_q && !abort_in;
   assign busy            = (st != W_IDLE);

   always_comb begin
      if (st == W_OREQ) begin
         idx = vpn_q[2*IDX_W-1:IDX_W];
         tbl = root_q;
      end else begin
         idx = vpn_q[IDX_W-1:0];
         tbl = leaf_tbl_q;
      end
   end

   assign mem_req_valid = ((st == W_OREQ) || (st == W_IREQ)) && !abort_in;
   assign mem_req_addr  = {tbl, idx, {PTE_BYTES_LG{1'b0}}};

   assign ins_en    = (st == W_IWAIT) && rsp_ok && pte_v;
   assign ins_frame = mem_rsp_data[PA_W-1:OFF_W];
   assign ins_ro    = mem_rsp_data[PTE_RO_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= W_IDLE;
         vpn_q       <= '0;
         root_q      <= '0;
         leaf_tbl_q  <= '0;
         aborted_q   <= 1'b0;
         done        <= 1'b0;
         done_status <= XS_OK;
         done_frame  <= '0;
         done_ro     <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st)
            W_IDLE: begin
               if (start) begin
                  vpn_q     <= start_vpn;
                  root_q    <= root_frame;
                  aborted_q <= 1'b0;
                  st        <= W_OREQ;
               end
            end
            W_OREQ, W_IREQ: begin
               if (abort_in) begin
                  done        <= 1'b1;
                  done_status <= XS_RETRY;
                  done_frame  <= '0;
                  done_ro     <= 1'b0;
                  st          <= W_IDLE;
               end else if (mem_req_ready) begin
                  st <= (st == W_OREQ) ? W_OWAIT : W_IWAIT;
               end
            end
            W_OWAIT, W_IWAIT: begin
               if (mem_rsp_valid) begin
                  if (!rsp_ok || !pte_v) begin
                     done        <= 1'b1;
                     done_status <= rsp_ok ? XS_INVALID : XS_RETRY;
                     done_frame  <= '0;
                     done_ro     <= 1'b0;
                     st          <= W_IDLE;
                  end else if (st == W_OWAIT) begin
                     leaf_tbl_q <= mem_rsp_data[PA_W-1:OFF_W];
                     st         <= W_IREQ;
                  end else begin
                     done        <= 1'b1;
                     done_status <= XS_OK;
                     done_frame  <= mem_rsp_data[PA_W-1:OFF_W];
                     done_ro     <= mem_rsp_data[PTE_RO_BIT];
                     st          <= W_IDLE;
                  end
               end else if (abort_in) begin
                  aborted_q <= 1'b1;
               end
            end
            default: st <= W_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/mmu_xlate.sv
`timescale 1ns/1ps
module mmu_xlate
   import mmu_pkg::*;
#(
   parameter int VA_W      = 32,
   parameter int OFF_W     = 12,
   parameter int IDX_W     = 10,
   parameter int TLB_DEPTH = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   output logic                    req_ready,
   input  logic [VA_W-1:0]         req_vaddr,
   input  logic                    req_write,
   output logic                    rsp_valid,
   output logic [1:0]              rsp_status,
   output logic [VA_W-1:0]         rsp_paddr,
   input  logic                    ptbr_we,
   input  logic [VA_W-OFF_W-1:0]   ptbr_frame,
   input  logic                    flush,
   output logic                    mem_req_valid,
   input  logic                    mem_req_ready,
   output logic [VA_W-1:0]         mem_req_addr,
   input  logic                    mem_rsp_valid,
   input  logic [VA_W-1:0]         mem_rsp_data
);
   localparam int VPN_W   = VA_W - OFF_W;
   localparam int FRAME_W = VPN_W;

   generate
      if (VPN_W != 2 * IDX_W) begin : g_bad_split
         $error("mmu_xlate: page number must split into two equal indices");
      end
   endgenerate

   logic [FRAME_W-1:0] root_q;
   logic               accept, lk_hit, lk_ro, hit_use, wk_start, wk_busy;
   logic [FRAME_W-1:0] lk_frame;
   logic               hit_q, hit_ro_q, wr_q;
   logic [FRAME_W-1:0] hit_frame_q;
   logic [OFF_W-1:0]   off_q;
   logic               ins_en, ins_ro, wk_done, wk_ro;
   logic [FRAME_W-1:0] ins_frame, wk_frame;
   logic [1:0]         wk_status;
   logic [VPN_W-1:0]   wk_vpn_q;
   xs_e                base_st, fin_st;
   logic [FRAME_W-1:0] sel_frame;
   logic               sel_ro;

   assign req_ready = !wk_busy;
   assign accept    = req_valid && req_ready;
   assign hit_use   = lk_hit && !flush;
   assign wk_start  = accept && !hit_use;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         root_q      <= '0;
         hit_q       <= 1'b0;
         hit_ro_q    <= 1'b0;
         hit_frame_q <= '0;
         wr_q        <= 1'b0;
         off_q       <= '0;
         wk_vpn_q    <= '0;
      end else begin
         if (ptbr_we) root_q <= ptbr_frame;
         hit_q <= accept && hit_use;
         if (accept) begin
            hit_ro_q    <= lk_ro;
            hit_frame_q <= lk_frame;
            wr_q        <= req_write;
            off_q       <= req_vaddr[OFF_W-1:0];
            wk_vpn_q    <= req_vaddr[VA_W-1:OFF_W];
         end
      end
   end

   mmu_tlb #(.TAG_W(VPN_W), .FRAME_W(FRAME_W), .DEPTH(TLB_DEPTH)) u_tlb (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_tag   (req_vaddr[VA_W-1:OFF_W]),
      .lk_hit   (lk_hit),
      .lk_frame (lk_frame),
      .lk_ro    (lk_ro),
      .clr      (flush),
      .ins_en   (ins_en),
      .ins_tag  (wk_vpn_q),
      .ins_frame(ins_frame),
      .ins_ro   (ins_ro)
   );

   mmu_walker #(.IDX_W(IDX_W), .FRAME_W(FRAME_W), .PA_W(VA_W)) u_walk (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (wk_start),
      .start_vpn    (req_vaddr[VA_W-1:OFF_W]),
      .root_frame   (root_q),
      .abort_in     (flush),
      .busy         (wk_busy),
      .mem_req_valid(mem_req_valid),
      .mem_req_ready(mem_req_ready),
      .mem_req_addr (mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data (mem_rsp_data),
      .ins_en       (ins_en),
      .ins_frame    (ins_frame),
      .ins_ro       (ins_ro),
      .done         (wk_done),
      .done_status  (wk_status),
      .done_frame   (wk_frame),
      .done_ro      (wk_ro)
   );

   always_comb begin
      if (hit_q) begin
         base_st   = XS_OK;
         sel_frame = hit_frame_q;
         sel_ro    = hit_ro_q;
      end else begin
         base_st   = xs_e'(wk_status);
         sel_frame = wk_frame;
         sel_ro    = wk_ro;
      end
      fin_st = (base_st == XS_OK && wr_q && sel_ro) ? XS_READONLY : base_st;
   end

   assign rsp_valid  = hit_q || wk_done;
   assign rsp_status = fin_st;
   assign rsp_paddr  = (rsp_valid && fin_st == XS_OK) ? {sel_frame, off_q} : '0;
endmodule

// File: rtl/mmu_xlate_chk.sv
`timescale 1ns/1ps
module mmu_xlate_chk #(
   parameter int VA_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_ready,
   input logic            rsp_valid,
   input logic [1:0]      rsp_status,
   input logic [VA_W-1:0] rsp_paddr,
   input logic            flush,
   input logic            mem_req_valid,
   input logic            mem_req_ready,
   input logic [VA_W-1:0] mem_req_addr
);
   // R3
   one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && mem_req_ready |=> !mem_req_valid);

   // R3
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> flush || (mem_req_valid && $stable(mem_req_addr)));

   // R12
   walk_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !req_ready);

   // R8
   flush_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush && !(req_valid && req_ready) |=> !mem_req_valid);

   // R4
   fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_status != 2'd0 |-> rsp_paddr == '0);
endmodule

bind mmu_xlate mmu_xlate_chk #(.VA_W(VA_W)) u_chk (.*);

// File: tb/mmu_xlate_bench.sv
`timescale 1ns/1ps
module mmu_xlate_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic        req_ready, rsp_valid;
   logic [1:0]  rsp_status;
   logic [31:0] rsp_paddr;
   logic        ptbr_we = 1'b0;
   logic [19:0] ptbr_frame = '0;
   logic        flush = 1'b0;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b1;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;

   int n_chk = 0, n_err = 0;
   int rd_cnt = 0;
   logic [31:0] rec_addr [4];
   logic [31:0] mem [16384];
   logic        pend = 1'b0;
   logic [31:0] pend_addr = '0;

   always #2 clk = ~clk;

   mmu_xlate u_mmu_xlate (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_vaddr(req_vaddr), .req_write(req_write), .rsp_valid(rsp_valid),
      .rsp_status(rsp_status), .rsp_paddr(rsp_paddr), .ptbr_we(ptbr_we),
      .ptbr_frame(ptbr_frame), .flush(flush), .mem_req_valid(mem_req_valid),
      .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
   );

   // memory model: acts 1 ns after each falling edge, one-cycle read latency
   initial begin
      forever begin
         @(negedge clk);
         #1;
         mem_rsp_valid = 1'b0;
         if (pend) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = (pend_addr[31:16] == 16'd0) ? mem[pend_addr[15:2]] : 32'd0;
            pend = 1'b0;
         end
         if (mem_req_valid && mem_req_ready) begin
            pend = 1'b1;
            pend_addr = mem_req_addr;
            rec_addr[rd_cnt % 4] = mem_req_addr;
            rd_cnt++;
         end
      end
   end

   function automatic logic [31:0] va(input int hi, input int lo, input int off);
      return {hi[9:0], lo[9:0], off[11:0]};
   endfunction

   function automatic logic [31:0] leaf_pa(input int lo, input int off);
      return ((32'h100 + lo) << 12) | off;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic xlate(input logic [31:0] a, input logic wr, input int flush_at,
                        output logic [1:0] st, output logic [31:0] pa,
                        output int lat, output int nrd);
      int n0 = rd_cnt;
      int i = 0;
      req_vaddr = a; req_write = wr; req_valid = 1'b1;
      flush = (flush_at == 0);
      st = 2'd0; pa = '0; lat = -1;
      while (1) begin
         @(posedge clk); @(negedge clk);
         i++;
         req_valid = 1'b0;
         if (rsp_valid) begin
            st = rsp_status; pa = rsp_paddr; lat = i;
            break;
         end
         flush = (i == flush_at);
         if (i > 60) begin
            chk(1'b0, "R12 response timeout", 32'(i), 32'd60);
            break;
         end
      end
      flush = 1'b0;
      nrd = rd_cnt - n0;
   endtask

   task automatic expect_x(input string tag, input logic [31:0] a, input logic wr,
                           input int flush_at, input logic [1:0] est,
                           input logic [31:0] epa, input int elat, input int enrd);
      logic [1:0] st; logic [31:0] pa; int lat, nrd;
      xlate(a, wr, flush_at, st, pa, lat, nrd);
      chk(st == est, {tag, " status"}, 32'(st), 32'(est));
      chk(pa == epa, {tag, " paddr"}, pa, epa);
      chk(nrd == enrd, {tag, " memory reads"}, 32'(nrd), 32'(enrd));
      if (elat >= 0) chk(lat == elat, {tag, " latency"}, 32'(lat), 32'(elat));
   endtask

   task automatic pulse_flush();
      flush = 1'b1; @(posedge clk); @(negedge clk); flush = 1'b0;
   endtask

   task automatic load_root(input logic [19:0] f);
      ptbr_frame = f; ptbr_we = 1'b1; @(posedge clk); @(negedge clk); ptbr_we = 1'b0;
   endtask

   task automatic t_reset();
      chk(req_ready == 1'b1, "R11 req_ready after reset", 32'(req_ready), 32'd1);
      chk(rsp_valid == 1'b0, "R11 rsp_valid after reset", 32'(rsp_valid), 32'd0);
      chk(mem_req_valid == 1'b0, "R11 mem_req_valid after reset", 32'(mem_req_valid), 32'd0);
   endtask

   task automatic t_walk_and_hit();
      int base;
      base = rd_cnt;
      expect_x("R3 R1 first walk", va(0, 3, 'h123), 1'b0, -1, 2'd0, leaf_pa(3, 'h123), 5, 2);
      chk(rec_addr[base % 4] == 32'h0000_1000, "R3 outer read address", rec_addr[base % 4], 32'h0000_1000);
      chk(rec_addr[(base + 1) % 4] == 32'h0000_200C, "R3 inner read address",
          rec_addr[(base + 1) % 4], 32'h0000_200C);
      expect_x("R2 R1 cached hit", va(0, 3, 'h456), 1'b0, -1, 2'd0, leaf_pa(3, 'h456), 1, 0);
      expect_x("R1 other outer slot", va(3, 0, 'hFFF), 1'b0, -1, 2'd0, 32'h00ABCFFF, 5, 2);
   endtask

   task automatic t_faults();
      expect_x("R4 invalid outer", va(1, 0, 0), 1'b0, -1, 2'd1, 32'd0, -1, 1);
      expect_x("R4 invalid leaf", va(0, 6, 8), 1'b0, -1, 2'd1, 32'd0, -1, 2);
      expect_x("R4 invalid not installed", va(0, 6, 8), 1'b0, -1, 2'd1, 32'd0, -1, 2);
      expect_x("R5 read of read-only page", va(0, 5, 'h10), 1'b0, -1, 2'd0, leaf_pa(5, 'h10), 5, 2);
      expect_x("R5 write to read-only hit", va(0, 5, 'h10), 1'b1, -1, 2'd2, 32'd0, 1, 0);
      expect_x("R5 write to writable hit", va(0, 3, 'h20), 1'b1, -1, 2'd0, leaf_pa(3, 'h20), 1, 0);
      pulse_flush();
      expect_x("R5 write to read-only walk", va(0, 5, 'h10), 1'b1, -1, 2'd2, 32'd0, 5, 2);
   endtask

   task automatic t_flush_idle();
      expect_x("R7 cached before flush", va(0, 3, 0), 1'b0, -1, 2'd0, leaf_pa(3, 0), -1, 2);
      expect_x("R7 hit before flush", va(0, 3, 4), 1'b0, -1, 2'd0, leaf_pa(3, 4), 1, 0);
      pulse_flush();
      expect_x("R7 walk after flush", va(0, 3, 4), 1'b0, -1, 2'd0, leaf_pa(3, 4), 5, 2);
   endtask

   task automatic t_evict();
      pulse_flush();
      for (int k = 0; k < 9; k++)
         expect_x("R6 fill", va(0, 10 + k, 0), 1'b0, -1, 2'd0, leaf_pa(10 + k, 0), 5, 2);
      expect_x("R6 second entry kept", va(0, 11, 'h5), 1'b0, -1, 2'd0, leaf_pa(11, 'h5), 1, 0);
      expect_x("R6 ninth entry cached", va(0, 18, 'h5), 1'b0, -1, 2'd0, leaf_pa(18, 'h5), 1, 0);
      expect_x("R6 first entry evicted", va(0, 10, 'h5), 1'b0, -1, 2'd0, leaf_pa(10, 'h5), 5, 2);
   endtask

   task automatic t_flush_walk();
      pulse_flush();
      expect_x("R8 flush before outer read", va(0, 20, 0), 1'b0, 1, 2'd3, 32'd0, 2, 0);
      expect_x("R8 flush with outer data", va(0, 20, 0), 1'b0, 2, 2'd3, 32'd0, 3, 1);
      expect_x("R8 flush before inner read", va(0, 20, 0), 1'b0, 3, 2'd3, 32'd0, 4, 1);
      expect_x("R8 flush with leaf data", va(0, 20, 0), 1'b0, 4, 2'd3, 32'd0, 5, 2);
      expect_x("R8 aborted walk not installed", va(0, 20, 'h7), 1'b0, -1, 2'd0, leaf_pa(20, 'h7), 5, 2);
   endtask

   task automatic t_flush_accept();
      expect_x("R9 page cached", va(0, 20, 'h8), 1'b0, -1, 2'd0, leaf_pa(20, 'h8), 1, 0);
      expect_x("R9 flush in accept cycle walks", va(0, 20, 'h9), 1'b0, 0, 2'd0, leaf_pa(20, 'h9), 5, 2);
   endtask

   task automatic t_root_switch();
      int base;
      pulse_flush();
      load_root(20'h4);
      base = rd_cnt;
      expect_x("R10 new root table", va(0, 0, 'h20), 1'b0, -1, 2'd0, 32'h00777020, 5, 2);
      chk(rec_addr[base % 4] == 32'h0000_4000, "R10 outer read address", rec_addr[base % 4], 32'h0000_4000);
      load_root(20'h1);
      pulse_flush();
      expect_x("R10 old root restored", va(0, 0, 'h20), 1'b0, -1, 2'd0, leaf_pa(0, 'h20), 5, 2);
   endtask

   task automatic t_pulse();
      logic seen;
      expect_x("R12 hit setup", va(0, 0, 'h1), 1'b0, -1, 2'd0, leaf_pa(0, 'h1), 1, 0);
      @(posedge clk); @(negedge clk);
      seen = rsp_valid;
      chk(seen == 1'b0, "R12 response is one cycle", 32'(seen), 32'd0);
      req_vaddr = va(0, 30, 0); req_write = 1'b0; req_valid = 1'b1;
      @(posedge clk); @(negedge clk);
      req_valid = 1'b0;
      @(posedge clk); @(negedge clk);
      chk(req_ready == 1'b0, "R12 busy during walk", 32'(req_ready), 32'd0);
      for (int w = 0; w < 10 && !rsp_valid; w++) begin
         @(posedge clk); @(negedge clk);
      end
      chk(rsp_valid == 1'b1, "R12 walk response", 32'(rsp_valid), 32'd1);
      @(posedge clk); @(negedge clk);
   endtask

   initial begin
      #(4 * 150000);
      n_chk++; n_err++;
      $display("FAIL watchdog: run did not complete in time");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16384; i++) mem[i] = 32'd0;
      mem[(32'h1000 >> 2) + 0] = 32'h0000_2001;
      mem[(32'h1000 >> 2) + 3] = 32'h0000_3001;
      for (int k = 0; k < 1024; k++) mem[(32'h2000 >> 2) + k] = ((32'h100 + k) << 12) | 32'd1;
      mem[(32'h2000 >> 2) + 5] = ((32'h100 + 5) << 12) | 32'd3;
      mem[(32'h2000 >> 2) + 6] = 32'd0;
      mem[(32'h3000 >> 2) + 0] = 32'h00AB_C001;
      mem[(32'h4000 >> 2) + 0] = 32'h0000_5001;
      mem[(32'h5000 >> 2) + 0] = 32'h0077_7001;

      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      load_root(20'h1);
      t_walk_and_hit();
      t_faults();
      t_flush_idle();
      t_evict();
      t_flush_walk();
      t_flush_accept();
      t_root_switch();
      t_pulse();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule